// File: doc/BRIEF.md
# Reference-Locked Acquisition Sequencer

This block starts a burst of converter samples whose first sample lines up with a periodic reference signal. Software-side logic writes three settings: how many reference cycles to integrate, how many samples to take in each cycle, and the reference frequency in hertz. From these the block computes two derived values, the conversion rate (samples per cycle times frequency) and the total burst length (cycles times samples per cycle). It refuses any write that would push the rate above 100 000 samples per second or the length above 65 536 samples. Each write is judged against the two settings already in force. A refused write leaves all three settings as they were.

A start request makes the block follow the reference through a high level, then a low level, and then wait for the next rising edge. On that edge it emits one trigger pulse. From then on it forwards conversion ticks to a downstream sink as sample strobes, and it stops once the burst length is reached. A tick that falls in the trigger cycle itself does not count. After the last strobe the block pulses an end-of-acquisition flag. Rate and length are recomputed only on a setting write. The start/trigger sequence runs again for every measurement.

Top module: `acq_sequencer`

## Requirements
- R1: After reset the settings are cycles 1, samples-per-cycle 1 and frequency 1. The published rate and length are both 1, and busy, trigger, strobe, done, start error and reject are all low.
- R2: An accepted write updates one setting, selected by a 2-bit selector (0 = cycles, 1 = samples per cycle, 2 = frequency). In the next cycle the published rate equals samples-per-cycle times frequency and the published length equals cycles times samples-per-cycle.
- R3: A write whose resulting rate exceeds 100 000 is refused. The reject output is high for exactly the following cycle, and the published rate, the published length and all settings keep their old values.
- R4: A write whose resulting length exceeds 65 536 is refused in the same way as in R3.
- R5: Legality is judged on the combination with the settings currently in force, so a value refused earlier is accepted after another setting has changed to make the combination legal.
- R6: A zero data value, or the selector value 3, is refused in the same way as in R3.
- R7: After a start request the block needs the reference high, then low. Only then does it fire a one-clock trigger on the next rising edge. The trigger appears 3 clocks after that edge reaches the reference input (a two-stage synchroniser followed by one register).
- R8: A conversion tick in the same cycle as the trigger pulse produces no strobe and is not counted.
- R9: Exactly as many strobes as the published length are produced. The done flag pulses once, in the cycle after the last strobe, and busy is low in that cycle.
- R10: A length of 65 536 is supported and yields 65 536 strobes.
- R11: A start request while busy produces a one-cycle start error pulse in the next cycle, and the running burst continues unchanged.
- R12: Conversion ticks while no burst is running produce no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Setting write strobe |
| cfg_sel | input | 2 | Setting selector: 0 cycles, 1 samples per cycle, 2 frequency |
| cfg_data | input | DATA_W | Value to write |
| cfg_reject | output | 1 | One-cycle pulse after a refused write |
| sample_rate | output | RATE_W | Published conversion rate |
| sample_total | output | CNT_W+1 | Published burst length |
| ref_in | input | 1 | Asynchronous periodic reference |
| conv_tick | input | 1 | Conversion clock pulse, one cycle wide |
| start | input | 1 | Arm and trigger request |
| busy | output | 1 | Sequence in progress |
| trig_out | output | 1 | One-clock trigger pulse |
| sample_strobe | output | 1 | Sample strobe to the sink |
| acq_done | output | 1 | End-of-acquisition pulse |
| start_err | output | 1 | Start requested while busy |

## Verification
A wrong down-counter value shows at the ports as one strobe too many or too few, and as a done pulse that is not one cycle after the last strobe. Both are visible by the end of the burst. A state machine that skips the high or low wait fires the trigger one reference period early. The bench counts rising reference edges between start and trigger, so this error shows within two reference periods. A legality error shows in the very next cycle, as a reject pulse that should not be there, or as published rate and length values that differ from the products the bench computes itself.

// File: rtl/acq_pkg.sv
package acq_pkg;

  typedef enum logic [1:0] {
    SEL_CYCLES = 2'd0,
    SEL_SPC    = 2'd1,
    SEL_FREQ   = 2'd2
  } cfg_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEEK_HI,
    ST_SEEK_LO,
    ST_SEEK_RISE,
    ST_RUN
  } seq_state_e;

  // conversions per second
  function automatic logic [63:0] rate_of(input logic [63:0] spc, input logic [63:0] freq);
    return spc * freq;
  endfunction

  // samples in one burst
  function automatic logic [63:0] length_of(input logic [63:0] cycles, input logic [63:0] spc);
    return cycles * spc;
  endfunction

  function automatic logic combo_legal(input logic [63:0] rate, input logic [63:0] len,
                                       input logic [63:0] lim_rate, input logic [63:0] lim_len);
    return (rate != 64'd0) && (len != 64'd0) && (rate <= lim_rate) && (len <= lim_len);
  endfunction

endpackage

// File: rtl/acq_param_regs.sv
module acq_param_regs
  import acq_pkg::*;
#(
  parameter int DATA_W   = 17,
  parameter int RATE_W   = 17,
  parameter int CNT_W    = 16,
  parameter int MAX_RATE = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [RATE_W-1:0] rate_o,
  output logic [CNT_W:0]    len_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic              reject_o
);
  localparam int          LEN_W    = CNT_W + 1;
  localparam logic [63:0] LIM_RATE = 64'(MAX_RATE);
  localparam logic [63:0] LIM_LEN  = 64'd1 << CNT_W;

  logic [DATA_W-1:0] cyc_q, spc_q, frq_q;
  logic [DATA_W-1:0] cyc_c, spc_c, frq_c;
  logic [63:0]       rate_c, len_c;
  logic              sel_ok, ok_c;
  logic [RATE_W-1:0] rate_q;
  logic [LEN_W-1:0]  len_q;
  logic              reject_q;

  always_comb begin
    cyc_c  = (sel == SEL_CYCLES) ? wdata : cyc_q;
    spc_c  = (sel == SEL_SPC)    ? wdata : spc_q;
    frq_c  = (sel == SEL_FREQ)   ? wdata : frq_q;
    sel_ok = (sel != 2'd3);
    rate_c = rate_of(64'(spc_c), 64'(frq_c));
    len_c  = length_of(64'(cyc_c), 64'(spc_c));
    ok_c   = sel_ok && combo_legal(rate_c, len_c, LIM_RATE, LIM_LEN);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_q    <= DATA_W'(1);
      spc_q    <= DATA_W'(1);
      frq_q    <= DATA_W'(1);
      rate_q   <= RATE_W'(1);
      len_q    <= LEN_W'(1);
      reject_q <= 1'b0;
    end else begin
      reject_q <= 1'b0;
      if (wr_en) begin
        if (ok_c) begin
          cyc_q  <= cyc_c;
          spc_q  <= spc_c;
          frq_q  <= frq_c;
          rate_q <= RATE_W'(rate_c);
          len_q  <= LEN_W'(len_c);
        end else begin
          reject_q <= 1'b1;
        end
      end
    end
  end

  assign rate_o     = rate_q;
  assign len_o      = len_q;
  assign load_val_o = CNT_W'(len_q - LEN_W'(1));
  assign reject_o   = reject_q;
endmodule

// File: rtl/acq_ref_sync.sv
module acq_ref_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_async,
  output logic ref_lvl,
  output logic ref_rise
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= ref_async;
      for (int i = 1; i <= STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign ref_lvl  = chain_q[STAGES-1];
  assign ref_rise = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/acq_trig_ctrl.sv
module acq_trig_ctrl
  import acq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ref_lvl,
  input  logic ref_rise,
  input  logic last_sample,
  output logic arm_fire,
  output logic run_phase,
  output logic busy_o,
  output logic trig_o,
  output logic err_o
);
  seq_state_e state_q, state_d;
  logic       trig_q, err_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (start)       state_d = ST_SEEK_HI;
      ST_SEEK_HI:   if (ref_lvl)     state_d = ST_SEEK_LO;
      ST_SEEK_LO:   if (!ref_lvl)    state_d = ST_SEEK_RISE;
      ST_SEEK_RISE: if (ref_rise)    state_d = ST_RUN;
      ST_RUN:       if (last_sample) state_d = ST_IDLE;
      default:                       state_d = ST_IDLE;
    endcase
  end

  assign arm_fire = (state_q == ST_SEEK_RISE) && ref_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      trig_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      trig_q  <= arm_fire;
      err_q   <= start && (state_q != ST_IDLE);
    end
  end

  assign run_phase = (state_q == ST_RUN);
  assign busy_o    = (state_q != ST_IDLE);
  assign trig_o    = trig_q;
  assign err_o     = err_q;
endmodule

// File: rtl/acq_sample_count.sv
module acq_sample_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run_phase,
  input  logic             trig,
  input  logic             tick,
  output logic             strobe,
  output logic             last_sample,
  output logic             done
);
  logic [CNT_W-1:0] remain_q;
  logic             done_q;

  assign strobe      = run_phase && tick && !trig;
  assign last_sample = strobe && (remain_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= last_sample;
      if (load) remain_q <= load_val;
      else if (strobe && remain_q != '0) remain_q <= remain_q - CNT_W'(1);
    end
  end

  assign done = done_q;
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer #(
  parameter int DATA_W   = 17,
  parameter int RATE_W   = 17,
  parameter int CNT_W    = 16,
  parameter int MAX_RATE = 100000,
  parameter int SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_data,
  output logic              cfg_reject,
  output logic [RATE_W-1:0] sample_rate,
  output logic [CNT_W:0]    sample_total,
  input  logic              ref_in,
  input  logic              conv_tick,
  input  logic              start,
  output logic              busy,
  output logic              trig_out,
  output logic              sample_strobe,
  output logic              acq_done,
  output logic              start_err
);
  logic [CNT_W-1:0] load_val;
  logic             ref_lvl, ref_rise;
  logic             arm_fire, run_phase, last_sample;

  acq_param_regs #(.DATA_W(DATA_W), .RATE_W(RATE_W), .CNT_W(CNT_W), .MAX_RATE(MAX_RATE)) u_params (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .sel(cfg_sel), .wdata(cfg_data),
    .rate_o(sample_rate), .len_o(sample_total), .load_val_o(load_val), .reject_o(cfg_reject)
  );

  acq_ref_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .ref_async(ref_in), .ref_lvl(ref_lvl), .ref_rise(ref_rise)
  );

  acq_trig_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_lvl(ref_lvl), .ref_rise(ref_rise),
    .last_sample(last_sample), .arm_fire(arm_fire), .run_phase(run_phase),
    .busy_o(busy), .trig_o(trig_out), .err_o(start_err)
  );

  acq_sample_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .load(arm_fire), .load_val(load_val), .run_phase(run_phase),
    .trig(trig_out), .tick(conv_tick), .strobe(sample_strobe), .last_sample(last_sample),
    .done(acq_done)
  );
endmodule

// File: rtl/acq_sequencer_chk.sv
module acq_sequencer_chk #(
  parameter int RATE_W   = 17,
  parameter int CNT_W    = 16,
  parameter int MAX_RATE = 100000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_reject,
  input logic [RATE_W-1:0] sample_rate,
  input logic [CNT_W:0]    sample_total,
  input logic              start,
  input logic              busy,
  input logic              trig_out,
  input logic              sample_strobe,
  input logic              acq_done,
  input logic              start_err,
  input logic              ref_rise,
  input logic              last_sample
);
  localparam logic [CNT_W:0] LEN_MAX = {1'b1, {CNT_W{1'b0}}};

  assert_rate_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(sample_rate) <= MAX_RATE);
  assert_len_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_total <= LEN_MAX) && (sample_total != '0));
  assert_reject_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_reject |-> ($stable(sample_rate) && $stable(sample_total)));
  assert_trig_after_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> $past(ref_rise));
  assert_trig_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |=> !trig_out);
  assert_no_strobe_on_trig_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> !sample_strobe);
  assert_done_follows_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acq_done |-> ($past(last_sample) && $past(sample_strobe) && !busy));
  assert_err_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start_err |-> ($past(start) && $past(busy)));
  assert_strobe_only_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |-> busy);
endmodule

bind acq_sequencer acq_sequencer_chk #(.RATE_W(RATE_W), .CNT_W(CNT_W), .MAX_RATE(MAX_RATE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_reject(cfg_reject), .sample_rate(sample_rate),
  .sample_total(sample_total), .start(start), .busy(busy), .trig_out(trig_out),
  .sample_strobe(sample_strobe), .acq_done(acq_done), .start_err(start_err),
  .ref_rise(ref_rise), .last_sample(last_sample)
);

// File: tb/tb_acq_sequencer.sv
module tb_acq_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int REF_P      = 20;
  localparam int DATA_W     = 17;
  localparam int RATE_W     = 17;
  localparam int CNT_W      = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_wr = 1'b0;
  logic [1:0]        cfg_sel = 2'd0;
  logic [DATA_W-1:0] cfg_data = '0;
  logic              cfg_reject;
  logic [RATE_W-1:0] sample_rate;
  logic [CNT_W:0]    sample_total;
  logic              ref_in = 1'b0;
  logic              conv_tick = 1'b0;
  logic              start = 1'b0;
  logic              busy, trig_out, sample_strobe, acq_done, start_err;

  acq_sequencer dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .cfg_reject(cfg_reject), .sample_rate(sample_rate), .sample_total(sample_total),
    .ref_in(ref_in), .conv_tick(conv_tick), .start(start), .busy(busy), .trig_out(trig_out),
    .sample_strobe(sample_strobe), .acq_done(acq_done), .start_err(start_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_errs = 0;
  // bench model of the settings
  longint m_cyc = 1, m_spc = 1, m_frq = 1;
  // per-step observation state
  int ref_ph = 0, step_idx = 0, since_rise = 100, since_trig = 0;
  int n_strobe, n_trig, n_done, n_rise, n_err, trig_rise, trig_lat;
  int last_strobe_idx, done_gap, trig_strobe, done_busy;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
  endtask

  task automatic clear_obs();
    n_strobe = 0; n_trig = 0; n_done = 0; n_rise = 0; n_err = 0;
    trig_rise = -1; trig_lat = -1; last_strobe_idx = -10; done_gap = -1;
    trig_strobe = 0; done_busy = 0; since_trig = 0;
  endtask

  // one clock: drive at negedge, sample 1 time unit later
  task automatic step(input int every, input bit on_trig);
    logic prev;
    @(negedge clk);
    prev = ref_in;
    ref_ph = (ref_ph + 1) % REF_P;
    ref_in = (ref_ph < REF_P/2);
    conv_tick = (on_trig && trig_out) || (every != 0 && (step_idx % every) == 0);
    step_idx++;
    if (ref_in && !prev) begin since_rise = 0; n_rise++; end
    else since_rise++;
    #1;
    since_trig++;
    if (trig_out) begin
      n_trig++;
      if (trig_rise < 0) begin trig_rise = n_rise; trig_lat = since_rise; end
      since_trig = 0;
      if (sample_strobe) trig_strobe++;
    end
    if (sample_strobe) begin n_strobe++; last_strobe_idx = step_idx; end
    if (acq_done) begin
      n_done++;
      done_gap = step_idx - last_strobe_idx;
      if (busy) done_busy++;
    end
    if (start_err) n_err++;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) step(0, 0);
    rst_n = 1'b1;
    step(0, 0);
    chk(sample_rate == 1, "R1 reset rate", sample_rate, 1);
    chk(sample_total == 1, "R1 reset total", sample_total, 1);
    chk({busy, trig_out, sample_strobe, acq_done, start_err, cfg_reject} == 6'b0,
        "R1 reset flags", {busy, trig_out, sample_strobe, acq_done, start_err, cfg_reject}, 0);
  endtask

  task automatic wr(input int sel, input longint val, input bit exp_ok, input string tag);
    longint c, s, f;
    c = (sel == 0) ? val : m_cyc;
    s = (sel == 1) ? val : m_spc;
    f = (sel == 2) ? val : m_frq;
    if (exp_ok) begin m_cyc = c; m_spc = s; m_frq = f; end
    cfg_wr = 1'b1; cfg_sel = 2'(sel); cfg_data = DATA_W'(val);
    step(0, 0);
    cfg_wr = 1'b0;
    chk(cfg_reject == !exp_ok, {tag, " reject"}, cfg_reject, !exp_ok);
    chk(sample_rate == m_spc * m_frq, {tag, " rate"}, sample_rate, m_spc * m_frq);
    chk(sample_total == m_cyc * m_spc, {tag, " total"}, sample_total, m_cyc * m_spc);
    step(0, 0);
    chk(cfg_reject == 1'b0, {tag, " reject one cycle"}, cfg_reject, 0);
  endtask

  task automatic t_params();
    wr(2, 1000, 1, "R2 freq");
    wr(1, 100, 1, "R2 spc");
    wr(1, 101, 0, "R3 rate over");
    wr(0, 655, 1, "R2 cycles");
    wr(0, 656, 0, "R4 length over");
    wr(2, 2000, 0, "R5 freq refused");
    wr(1, 50, 1, "R5 spc lowered");
    wr(2, 2000, 1, "R5 freq accepted");
    wr(0, 0, 0, "R6 zero");
    wr(3, 5, 0, "R6 selector 3");
  endtask

  // start_ph < REF_P/2 means start during the high phase
  task automatic run_acq(input int start_ph, input int every, input bit on_trig,
                         input int err_at, input string tag);
    longint exp_len;
    bit err_sent;
    exp_len = m_cyc * m_spc;
    err_sent = 0;
    clear_obs();
    while (ref_ph != start_ph) step(1, 0);
    chk(n_strobe == 0, {tag, " R12 idle ticks"}, n_strobe, 0);
    clear_obs();
    start = 1'b1;
    step(every, on_trig);
    start = 1'b0;
    for (int i = 0; i < 140000 && n_done == 0; i++) begin
      if (err_at != 0 && !err_sent && n_trig == 1 && since_trig == err_at) begin
        start = 1'b1;
        step(every, on_trig);
        start = 1'b0;
        err_sent = 1;
        chk(start_err == 1'b1, {tag, " R11 start error pulse"}, start_err, 1);
      end else begin
        step(every, on_trig);
      end
    end
    chk(trig_rise == ((start_ph < REF_P/2) ? 1 : 2), {tag, " R7 trigger edge"}, trig_rise,
        (start_ph < REF_P/2) ? 1 : 2);
    chk(trig_lat == 3, {tag, " R7 trigger latency"}, trig_lat, 3);
    chk(n_trig == 1, {tag, " R7 single trigger"}, n_trig, 1);
    chk(trig_strobe == 0, {tag, " R8 no strobe on trigger"}, trig_strobe, 0);
    chk(n_strobe == exp_len, {tag, " R9 strobe count"}, n_strobe, exp_len);
    chk(n_done == 1 && done_gap == 1, {tag, " R9 done timing"}, done_gap, 1);
    chk(done_busy == 0, {tag, " R9 busy low at done"}, done_busy, 0);
    chk(n_err == (err_at != 0 ? 1 : 0), {tag, " R11 error count"}, n_err, err_at != 0 ? 1 : 0);
    n_strobe = 0;
    repeat (5) step(1, 0);
    chk(n_strobe == 0 && busy == 1'b0, {tag, " R12 ticks after done"}, n_strobe, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++; n_errs++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    t_reset();
    t_params();
    wr(0, 3, 1, "R2 small cycles");
    wr(1, 4, 1, "R2 small spc");
    run_acq(15, 3, 0, 0, "low start");
    run_acq(5, 2, 1, 0, "coincident tick");
    run_acq(15, 1, 0, 4, "busy start");
    wr(1, 16, 1, "R2 spc 16");
    wr(0, 4096, 1, "R10 cycles 4096");
    chk(sample_total == 65536, "R10 total 65536", sample_total, 65536);
    run_acq(5, 1, 0, 0, "R10 full length");
    report();
    $finish;
  end
endmodule